// File: doc/BRIEF.md
# Deep Low-Power Entry Controller

This block decides when a system may drop into a deep low-power state and which of two depths it takes. Software arms the request by putting the CPU to sleep with its deep-sleep qualifier set; the block then waits for the radio to report idle and for every enabled wake-up source to be quiet. A single select bit picks the depth. The shallow depth keeps the always-on domain alive on the low-power regulator, holds RAM contents per bank and can be woken by internal events. The deep depth turns every regulator and clock off and can only be left by a low pulse on the external reset pad, which then acts like a power-on reset.

The controller sequences power-domain disable one clock ahead of retention enable. On wake it requests a reboot of the interruptible domain and records which sources fired in a sticky reason register that software clears by writing ones. A watchdog event during retention produces a system reset request rather than a wake reason. Regulators, oscillators and the timers that raise wake events lie outside the block and appear as plain inputs; all inputs are assumed synchronous to `clk`.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After reset the block is in the running state: `intr_dom_on`, `clk_en`, `main_reg_on` and `lp_reg_on` are 1; `ret_en`, `ram_ret`, `wake_reason`, `reboot_req` and `sys_rst_req` are 0.
- R2: A request is accepted only on a cycle where `radio_idle`, `cpu_sleep` and `cpu_deep` are all 1 and no bit of `wake_src & wake_en` is 1; a source that is high but has its `wake_en` bit at 0 does not block.
- R3: With `mode_sel` = 0 at acceptance, the cycle after acceptance shows `intr_dom_on`, `clk_en` and `ret_en` all 0; the following cycle shows `ret_en` = 1, `main_reg_on` = 0 and `lp_reg_on` = 1.
- R4: While retained, `ram_ret[0]` is 1 and `ram_ret[i]` (i ≥ 1) equals `bank_keep[i-1]` as sampled at acceptance; later changes of `bank_keep` have no effect. Outside retention `ram_ret` is 0.
- R5: While retained, a 0→1 transition on a `wake_src` bit whose `wake_en` bit is 1 ends retention: the next cycle shows `reboot_req` = 1 for exactly one cycle with `intr_dom_on` and `clk_en` back at 1. Edges on disabled sources, and a source already high when its enable is set, do not wake.
- R6: `wake_reason[i]` is set by the wake edge of source i (bit 0 radio timer, bit 1 CPU-host timer, bit 2 RTC, bits 3 and up GPIO lines), stays set, and is cleared only by a 1 in `reason_clr[i]`, by reset or by a shutdown exit; clearing an unset bit leaves the others untouched.
- R7: A `wdog_evt` while retained gives one cycle with `sys_rst_req` = 1 and `reboot_req` = 1 and sets no `wake_reason` bit.
- R8: With `mode_sel` = 1 at acceptance, after the one-cycle disable step all of `intr_dom_on`, `clk_en`, `main_reg_on`, `lp_reg_on`, `ret_en` and `ram_ret` are 0, and wake sources and `wdog_evt` have no effect.
- R9: Shutdown is left only after `pad_rst_n` has been sampled 0 and then 1; the cycle after the release shows `reboot_req` = 1 and `wake_reason` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| radio_idle | input | 1 | Radio has no activity |
| cpu_sleep | input | 1 | CPU is waiting for interrupt |
| cpu_deep | input | 1 | Deep-sleep qualifier from the CPU |
| mode_sel | input | 1 | 0 = retention depth, 1 = shutdown depth |
| bank_keep | input | NUM_BANKS-1 | Retention choice for RAM banks 1 and up |
| wake_src | input | NUM_WAKE | Wake-up event levels |
| wake_en | input | NUM_WAKE | Per-source enable (1 = used) |
| wdog_evt | input | 1 | Watchdog expiry |
| pad_rst_n | input | 1 | External reset pad level, synchronised |
| reason_clr | input | NUM_WAKE | Write-one-to-clear strobe for the reason register |
| intr_dom_on | output | 1 | Interruptible domain power enable |
| clk_en | output | 1 | System and bus clock enable |
| main_reg_on | output | 1 | Main regulator enable |
| lp_reg_on | output | 1 | Low-power regulator enable |
| ret_en | output | 1 | Retention enable for the always-on domain |
| ram_ret | output | NUM_BANKS | Per-bank RAM retention |
| wake_reason | output | NUM_WAKE | Sticky wake cause bits |
| reboot_req | output | 1 | One-cycle reset/reboot request of the interruptible domain |
| sys_rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The bench builds the block with NUM_WAKE = 6 and NUM_BANKS = 4, so the three timer sources and three GPIO lines can each be driven and checked by bit index, and every bank of the retention vector, including an unretained middle bank, is visible. With that width the blocking of entry by an enabled source, the level-without-edge case, the watchdog path and the per-bit clearing of the reason register are all reached with short directed sequences, and the pad-release exit from shutdown is seen to wipe a reason bit set by an earlier wake.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power entry controller.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_ENTER = 3'd1,
        ST_RET   = 3'd2,
        ST_SHUT  = 3'd3,
        ST_WAKE  = 3'd4
    } lpm_state_e;
endpackage

// File: rtl/lpm_wake_detect.sv
// Wake-source front end: detects rising edges, qualifies them with the
// enables, and keeps the sticky reason register.
// Assumes sources are synchronous to clk.
module lpm_wake_detect #(
    parameter int NUM_WAKE = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAKE-1:0] src,
    input  logic [NUM_WAKE-1:0] en,
    input  logic                capture,
    input  logic                clr_all,
    input  logic [NUM_WAKE-1:0] clr_w1c,
    output logic                hit,
    output logic                active,
    output logic [NUM_WAKE-1:0] reason
);
    logic [NUM_WAKE-1:0] src_q;
    logic [NUM_WAKE-1:0] rise_en;

    // Previous source levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    // Enabled rising edges and enabled active levels.
    always_comb begin
        rise_en = src & ~src_q & en;
        hit     = |rise_en;
        active  = |(src & en);
    end

    // Sticky reason bits with write-one-to-clear; a new set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       reason <= '0;
        else if (clr_all) reason <= '0;
        else              reason <= (reason & ~clr_w1c) | (capture ? rise_en : '0);
    end
endmodule

// File: rtl/lpm_seq.sv
// Sequencer FSM: RUN -> ENTER -> RET or SHUT -> WAKE -> RUN.
// ENTER lasts one cycle so the domain switches off before retention.
module lpm_seq
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_ok,
    input  logic       mode_sel,
    input  logic       wake_hit,
    input  logic       wdog_evt,
    input  logic       pad_rst_n,
    output lpm_state_e state,
    output logic       mode_q,
    output logic       wd_flag,
    output logic       shut_exit
);
    lpm_state_e nxt;
    logic       pad_seen;

    // Exit from shutdown needs a sampled low followed by a high.
    always_comb shut_exit = (state == ST_SHUT) && pad_seen && pad_rst_n;

    // Next-state decision.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (entry_ok) nxt = ST_ENTER;
            ST_ENTER: if (mode_q)        nxt = ST_SHUT;
                      else if (wake_hit) nxt = ST_WAKE;
                      else               nxt = ST_RET;
            ST_RET:   if (wdog_evt || wake_hit) nxt = ST_WAKE;
            ST_SHUT:  if (shut_exit) nxt = ST_WAKE;
            ST_WAKE:  nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // State, selected depth, watchdog cause and pad-low memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            mode_q   <= 1'b0;
            wd_flag  <= 1'b0;
            pad_seen <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && entry_ok) mode_q <= mode_sel;
            wd_flag  <= (state == ST_RET) && wdog_evt;
            pad_seen <= (state == ST_SHUT) && (pad_seen || !pad_rst_n);
        end
    end
endmodule

// File: rtl/lpm_ret_map.sv
// Per-bank RAM retention: bank 0 always kept, others by a captured bit.
module lpm_ret_map #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic                 ret_on,
    input  logic [NUM_BANKS-2:0] keep,
    output logic [NUM_BANKS-1:0] ram_ret
);
    logic [NUM_BANKS-2:0] keep_q;

    // Hold the bank choices taken at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)       keep_q <= '0;
        else if (capture) keep_q <= keep;
    end

    assign ram_ret[0] = ret_on;
    for (genvar b = 1; b < NUM_BANKS; b++) begin : g_bank
        assign ram_ret[b] = ret_on & keep_q[b-1];
    end
endmodule

// File: rtl/lpm_entry_ctrl.sv
// Top of the low-power entry controller. Decides entry, drives power,
// clock and retention enables from the sequencer state, reports wake
// causes. Synchronous active-low reset acts as power-on reset.
module lpm_entry_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_WAKE  = 31,
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 radio_idle,
    input  logic                 cpu_sleep,
    input  logic                 cpu_deep,
    input  logic                 mode_sel,
    input  logic [NUM_BANKS-2:0] bank_keep,
    input  logic [NUM_WAKE-1:0]  wake_src,
    input  logic [NUM_WAKE-1:0]  wake_en,
    input  logic                 wdog_evt,
    input  logic                 pad_rst_n,
    input  logic [NUM_WAKE-1:0]  reason_clr,
    output logic                 intr_dom_on,
    output logic                 clk_en,
    output logic                 main_reg_on,
    output logic                 lp_reg_on,
    output logic                 ret_en,
    output logic [NUM_BANKS-1:0] ram_ret,
    output logic [NUM_WAKE-1:0]  wake_reason,
    output logic                 reboot_req,
    output logic                 sys_rst_req
);
    lpm_state_e state;
    logic       mode_q, wd_flag, shut_exit;
    logic       wake_hit, src_active, entry_ok, capture;

    // Entry condition and reason capture window.
    always_comb begin
        entry_ok = radio_idle && cpu_sleep && cpu_deep && !src_active;
        capture  = (state == ST_RET) || (state == ST_ENTER && !mode_q);
    end

    lpm_wake_detect #(.NUM_WAKE(NUM_WAKE)) u_wake (
        .clk(clk), .rst_n(rst_n), .src(wake_src), .en(wake_en),
        .capture(capture), .clr_all(shut_exit), .clr_w1c(reason_clr),
        .hit(wake_hit), .active(src_active), .reason(wake_reason)
    );

    lpm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .entry_ok(entry_ok), .mode_sel(mode_sel),
        .wake_hit(wake_hit), .wdog_evt(wdog_evt), .pad_rst_n(pad_rst_n),
        .state(state), .mode_q(mode_q), .wd_flag(wd_flag), .shut_exit(shut_exit)
    );

    lpm_ret_map #(.NUM_BANKS(NUM_BANKS)) u_ret (
        .clk(clk), .rst_n(rst_n), .capture(state == ST_RUN && entry_ok),
        .ret_on(ret_en), .keep(bank_keep), .ram_ret(ram_ret)
    );

    // Power, clock and request outputs decoded from the state.
    always_comb begin
        intr_dom_on = (state == ST_RUN) || (state == ST_WAKE);
        clk_en      = intr_dom_on;
        main_reg_on = (state != ST_RET) && (state != ST_SHUT);
        lp_reg_on   = (state != ST_SHUT);
        ret_en      = (state == ST_RET);
        reboot_req  = (state == ST_WAKE);
        sys_rst_req = (state == ST_WAKE) && wd_flag;
    end
endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
// Property checker for lpm_entry_ctrl, attached with bind.
module lpm_entry_ctrl_chk #(
    parameter int NUM_WAKE  = 31,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 radio_idle,
    input logic                 cpu_sleep,
    input logic                 cpu_deep,
    input logic [NUM_WAKE-1:0]  wake_src,
    input logic [NUM_WAKE-1:0]  wake_en,
    input logic                 intr_dom_on,
    input logic                 clk_en,
    input logic                 main_reg_on,
    input logic                 lp_reg_on,
    input logic                 ret_en,
    input logic [NUM_BANKS-1:0] ram_ret,
    input logic                 reboot_req,
    input logic                 sys_rst_req
);
    // R2: domain only switches off after a cycle meeting the entry rule.
    a_r2_entry_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_dom_on) |-> $past(radio_idle && cpu_sleep && cpu_deep
                                     && ((wake_src & wake_en) == '0)));

    // R3: retention never starts in the cycle the domain is still on.
    a_r3_disable_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !$past(ret_en)) |-> !$past(intr_dom_on));

    // R4: bank 0 is kept whenever retention is on.
    a_r4_bank0_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> ram_ret[0]);

    // R5: the reboot request lasts one cycle.
    a_r5_reboot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req);

    // R7: a watchdog reset always comes with the reboot request.
    a_r7_wdog_reboot: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> reboot_req);

    // R8: with the low-power regulator off nothing else is on.
    a_r8_shut_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_reg_on |-> (!main_reg_on && !clk_en && !ret_en && ram_ret == '0));
endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk #(.NUM_WAKE(NUM_WAKE), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .radio_idle(radio_idle), .cpu_sleep(cpu_sleep),
    .cpu_deep(cpu_deep), .wake_src(wake_src), .wake_en(wake_en),
    .intr_dom_on(intr_dom_on), .clk_en(clk_en), .main_reg_on(main_reg_on),
    .lp_reg_on(lp_reg_on), .ret_en(ret_en), .ram_ret(ram_ret),
    .reboot_req(reboot_req), .sys_rst_req(sys_rst_req)
);

// File: tb/lpm_entry_ctrl_test.sv
// Directed bench for lpm_entry_ctrl: one task per scenario.
module lpm_entry_ctrl_test;
    localparam int NW = 6;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          radio_idle = 1'b0, cpu_sleep = 1'b0, cpu_deep = 1'b0;
    logic          mode_sel = 1'b0, wdog_evt = 1'b0, pad_rst_n = 1'b1;
    logic [NB-2:0] bank_keep = '0;
    logic [NW-1:0] wake_src = '0, wake_en = '0, reason_clr = '0;
    logic          intr_dom_on, clk_en, main_reg_on, lp_reg_on, ret_en;
    logic [NB-1:0] ram_ret;
    logic [NW-1:0] wake_reason;
    logic          reboot_req, sys_rst_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lpm_entry_ctrl #(.NUM_WAKE(NW), .NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .radio_idle(radio_idle), .cpu_sleep(cpu_sleep),
        .cpu_deep(cpu_deep), .mode_sel(mode_sel), .bank_keep(bank_keep),
        .wake_src(wake_src), .wake_en(wake_en), .wdog_evt(wdog_evt),
        .pad_rst_n(pad_rst_n), .reason_clr(reason_clr),
        .intr_dom_on(intr_dom_on), .clk_en(clk_en), .main_reg_on(main_reg_on),
        .lp_reg_on(lp_reg_on), .ret_en(ret_en), .ram_ret(ram_ret),
        .wake_reason(wake_reason), .reboot_req(reboot_req), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Accept a request: one negedge later the disable cycle is visible.
    task automatic request(input logic mode);
        mode_sel = mode; radio_idle = 1'b1; cpu_sleep = 1'b1; cpu_deep = 1'b1;
        step();
        cpu_sleep = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 intr_dom_on", intr_dom_on, 1);
        chk("R1 clk/main/lp", {clk_en, main_reg_on, lp_reg_on}, 3'b111);
        chk("R1 ret/ram_ret", {ret_en, ram_ret}, 0);
        chk("R1 reason/reqs", {wake_reason, reboot_req, sys_rst_req}, 0);
    endtask

    task automatic t_retention_wake();
        bank_keep = 3'b101; wake_en = 6'b000010;
        request(1'b0);
        chk("R3 disable step", {intr_dom_on, clk_en, ret_en}, 3'b000);
        bank_keep = 3'b000;
        step();
        chk("R3 retained", {ret_en, main_reg_on, lp_reg_on}, 3'b101);
        chk("R4 ram_ret", ram_ret, 4'b1011);
        wake_src = 6'b000001;
        step();
        chk("R5 disabled edge ignored", {ret_en, wake_reason}, {1'b1, 6'b0});
        wake_src = 6'b000010;
        step();
        chk("R5 wake", {reboot_req, intr_dom_on, clk_en, ret_en}, 4'b1110);
        chk("R6 reason set", wake_reason, 6'b000010);
        chk("R4 ram_ret off", ram_ret, 0);
        step();
        chk("R5 one-cycle reboot", reboot_req, 0);
        chk("R6 reason sticky", wake_reason, 6'b000010);
    endtask

    task automatic t_block_and_wdog();
        // source 1 still high and enabled
        radio_idle = 1'b1; cpu_sleep = 1'b1; cpu_deep = 1'b1; mode_sel = 1'b0;
        step(); step();
        chk("R2 blocked by enabled source", intr_dom_on, 1);
        wake_en = '0; cpu_deep = 1'b0;
        step(); step();
        chk("R2 blocked without deep qualifier", intr_dom_on, 1);
        cpu_deep = 1'b1;
        step();
        cpu_sleep = 1'b0;
        chk("R2 disabled source does not block", intr_dom_on, 0);
        step();
        wake_en = 6'b000010;
        step(); step();
        chk("R5 level without edge no wake", {ret_en, reboot_req}, 2'b10);
        wdog_evt = 1'b1;
        step();
        wdog_evt = 1'b0;
        chk("R7 watchdog reset", {sys_rst_req, reboot_req}, 2'b11);
        chk("R7 no reason bit", wake_reason, 6'b000010);
        step();
        chk("R7 back to run", {intr_dom_on, sys_rst_req}, 2'b10);
        wake_src = '0;
    endtask

    task automatic t_shutdown();
        wake_en = '1;
        step();
        request(1'b1);
        chk("R8 disable step", {intr_dom_on, lp_reg_on}, 2'b01);
        step();
        chk("R8 all off", {intr_dom_on, clk_en, main_reg_on, lp_reg_on, ret_en, ram_ret}, 0);
        wake_src = 6'b000100; wdog_evt = 1'b1;
        step();
        wdog_evt = 1'b0;
        chk("R8 wake and watchdog ignored", {lp_reg_on, reboot_req, sys_rst_req, wake_reason},
            {3'b000, 6'b000010});
        wake_src = '0;
        step();
        pad_rst_n = 1'b0;
        step(); step();
        chk("R9 still down while pad low", {lp_reg_on, reboot_req}, 2'b00);
        pad_rst_n = 1'b1;
        step();
        chk("R9 exit", {reboot_req, lp_reg_on, intr_dom_on}, 3'b111);
        chk("R9 reason cleared", wake_reason, 0);
        step();
    endtask

    task automatic t_clear();
        wake_en = 6'b010000;
        request(1'b0);
        step();
        wake_src = 6'b010000;
        step();
        chk("R6 gpio reason", wake_reason, 6'b010000);
        wake_src = '0; reason_clr = 6'b000001;
        step();
        reason_clr = '0;
        chk("R6 clear of unset bit", wake_reason, 6'b010000);
        reason_clr = 6'b010000;
        step();
        reason_clr = '0;
        chk("R6 write-one-to-clear", wake_reason, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_retention_wake();
        t_block_and_wdog();
        t_shutdown();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule